// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Flag Bank

This block holds a small bank of hardware lock flags that two agents share: a left port and a right port. The flags sit in their own address space, apart from any main memory. A port reaches them only while its active-low flag-space select is low. It drives them with ordinary SRAM-style controls: an active-low chip enable, a read/write line, an active-low lowest-byte enable, an address and write data.

To claim a flag, a port writes 0 to it. It then reads the flag back to learn whether it really holds it. The owner sees 0 and every other reader sees 1. The owner frees the flag by writing 1. A claim made while the other port holds the flag is not lost. It stays pending and takes effect by itself when the holder frees the flag. If both ports claim a free flag in the same clock, the left port wins.

All state is synchronous to one clock. Read data is registered and appears one cycle after the read.

Top module: `sem_flag_bank`

## Requirements
- R1: After reset, no flag has an owner and no claim is pending. Every read of any flag from either port returns all ones, and both read-data outputs rest at all ones.
- R2: A port access counts only in a cycle where its flag-space select, chip enable and lowest-byte enable are all low. In any other cycle the port changes no flag, and its read data the next cycle is all ones. A port that does not read in a cycle also shows all ones the next cycle.
- R3: The low $clog2(NUM_FLAGS) address bits choose the flag, so bits [2:0] by default. Higher address bits are ignored, and an access to one flag leaves every other flag unchanged.
- R4: A write (read/write line low) with write-data bit 0 equal to 0 claims the flag, and a free flag becomes owned by the writing port. Only bit 0 of the write data matters.
- R5: A read (read/write line high) returns, on the following cycle, all bits 0 if the reading port owns the flag and all bits 1 otherwise. The value reflects the flag state at the start of the read cycle.
- R6: When the owner writes 1 (bit 0 of the write data) and the other port has no claim, either pending or made in the same cycle, the flag becomes free.
- R7: A claim by a port while the other port owns the flag becomes pending. When the owner writes 1, ownership passes to the port whose claim is pending, or to a port that claims in that same cycle.
- R8: When both ports claim a free flag in the same cycle, the left port becomes owner and the right claim becomes pending.
- R9: A write of 0 by the port that already owns a flag changes nothing. A write of 1 by a port that does not own the flag leaves ownership unchanged, but cancels that port's own pending claim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l_sem_n | input | 1 | Left flag-space select, active low |
| l_ce_n | input | 1 | Left chip enable, active low |
| l_we_n | input | 1 | Left read/write: 0 write, 1 read |
| l_be0_n | input | 1 | Left lowest-byte enable, active low |
| l_addr | input | ADDR_W | Left address; low bits pick the flag |
| l_wdata | input | DATA_W | Left write data; bit 0 significant |
| l_rdata | output | DATA_W | Left read data, registered |
| r_sem_n | input | 1 | Right flag-space select, active low |
| r_ce_n | input | 1 | Right chip enable, active low |
| r_we_n | input | 1 | Right read/write: 0 write, 1 read |
| r_be0_n | input | 1 | Right lowest-byte enable, active low |
| r_addr | input | ADDR_W | Right address; low bits pick the flag |
| r_wdata | input | DATA_W | Right write data; bit 0 significant |
| r_rdata | output | DATA_W | Right read data, registered |

## Verification
The assertions watch, on every cycle, the rules local to one flag. A pending claim exists only while someone holds the flag. A holder keeps the flag until it writes 1. A release hands the flag to a pending claimant. A tie goes to the left port. An untouched flag holds still. Idle read ports show all ones. A port decodes at most one flag. What each port actually reads back after a sequence of claims, releases, cancels and disqualified accesses can be shown only by the bench's sweep. That sweep covers every pairing of left and right operations on every flag, on the same flag and on neighbouring ones, and compares each read against an arithmetic model of ownership.

// File: rtl/sem_pkg.sv
package sem_pkg;

   typedef enum logic [1:0] {
      OWN_NONE  = 2'd0,
      OWN_LEFT  = 2'd1,
      OWN_RIGHT = 2'd2
   } owner_e;

   // pend marks a claim from the port that is not the owner
   typedef struct packed {
      owner_e owner;
      logic   pend;
   } flag_t;

   function automatic flag_t flag_next(flag_t cur,
                                       logic lreq, logic lrel,
                                       logic rreq, logic rrel);
      flag_t nxt;
      nxt = cur;
      case (cur.owner)
         OWN_NONE: begin
            if (lreq) begin
               nxt.owner = OWN_LEFT;
               nxt.pend  = rreq;
            end else if (rreq) begin
               nxt.owner = OWN_RIGHT;
               nxt.pend  = 1'b0;
            end
         end
         OWN_LEFT: begin
            if (lrel) begin
               nxt.owner = (cur.pend || rreq) ? OWN_RIGHT : OWN_NONE;
               nxt.pend  = 1'b0;
            end else if (rreq) begin
               nxt.pend = 1'b1;
            end else if (rrel) begin
               nxt.pend = 1'b0;
            end
         end
         OWN_RIGHT: begin
            if (rrel) begin
               nxt.owner = (cur.pend || lreq) ? OWN_LEFT : OWN_NONE;
               nxt.pend  = 1'b0;
            end else if (lreq) begin
               nxt.pend = 1'b1;
            end else if (lrel) begin
               nxt.pend = 1'b0;
            end
         end
         default: begin
            nxt.owner = OWN_NONE;
            nxt.pend  = 1'b0;
         end
      endcase
      return nxt;
   endfunction

endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode #(
   parameter int NUM_FLAGS = 8,
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 8,
   localparam int SEL_W    = $clog2(NUM_FLAGS)
) (
   input  logic                 sem_n,
   input  logic                 ce_n,
   input  logic                 we_n,
   input  logic                 be0_n,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [DATA_W-1:0]    wdata,
   output logic                 acc_rd,
   output logic [SEL_W-1:0]     idx,
   output logic [NUM_FLAGS-1:0] req,
   output logic [NUM_FLAGS-1:0] rel
);
   logic acc, acc_wr;
   logic unused_bits;

   assign acc    = ~sem_n & ~ce_n & ~be0_n;
   assign acc_rd = acc & we_n;
   assign acc_wr = acc & ~we_n;
   assign idx    = addr[SEL_W-1:0];
   assign unused_bits = ^{addr, wdata};

   for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_dec
      logic hit;
      assign hit    = acc_wr && (idx == SEL_W'(i));
      assign req[i] = hit & ~wdata[0];
      assign rel[i] = hit &  wdata[0];
   end
endmodule

// File: rtl/sem_flag_cell.sv
module sem_flag_cell
   import sem_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req_l,
   input  logic rel_l,
   input  logic req_r,
   input  logic rel_r,
   output logic view_l,
   output logic view_r
);
   flag_t cur_q, nxt;

   assign nxt = flag_next(cur_q, req_l, rel_l, req_r, rel_r);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_q.owner <= OWN_NONE;
         cur_q.pend  <= 1'b0;
      end else begin
         cur_q <= nxt;
      end
   end

   assign view_l = (cur_q.owner != OWN_LEFT);
   assign view_r = (cur_q.owner != OWN_RIGHT);

   assert_pend_owned_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cur_q.pend |-> cur_q.owner != OWN_NONE);

   assert_hold_left_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_q.owner == OWN_LEFT && !rel_l) |=> cur_q.owner == OWN_LEFT);

   assert_hold_right_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_q.owner == OWN_RIGHT && !rel_r) |=> cur_q.owner == OWN_RIGHT);

   assert_handoff_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_q.owner == OWN_LEFT && rel_l && cur_q.pend) |=> cur_q.owner == OWN_RIGHT);

   assert_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_q.owner == OWN_RIGHT && rel_r && !cur_q.pend && !req_l)
      |=> cur_q.owner == OWN_NONE);

   assert_tie_left_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_q.owner == OWN_NONE && req_l && req_r)
      |=> (cur_q.owner == OWN_LEFT && cur_q.pend));

   assert_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_l || rel_l || req_r || rel_r) |=> $stable(cur_q));
endmodule

// File: rtl/sem_read_port.sv
module sem_read_port #(
   parameter int NUM_FLAGS = 8,
   parameter int DATA_W    = 8,
   localparam int SEL_W    = $clog2(NUM_FLAGS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 acc_rd,
   input  logic [SEL_W-1:0]     idx,
   input  logic [NUM_FLAGS-1:0] view,
   output logic [DATA_W-1:0]    rdata
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         rdata <= '1;
      else if (acc_rd)
         rdata <= {DATA_W{view[idx]}};
      else
         rdata <= '1;
   end

   assert_idle_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_rd |=> &rdata);

   assert_replicated_R5: assert property (@(posedge clk) disable iff (!rst_n)
      acc_rd |=> (&rdata || rdata == '0));
endmodule

// File: rtl/sem_flag_bank.sv
module sem_flag_bank #(
   parameter int NUM_FLAGS = 8,
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l_sem_n,
   input  logic              l_ce_n,
   input  logic              l_we_n,
   input  logic              l_be0_n,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [DATA_W-1:0] l_wdata,
   output logic [DATA_W-1:0] l_rdata,
   input  logic              r_sem_n,
   input  logic              r_ce_n,
   input  logic              r_we_n,
   input  logic              r_be0_n,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic [DATA_W-1:0] r_wdata,
   output logic [DATA_W-1:0] r_rdata
);
   localparam int SEL_W = $clog2(NUM_FLAGS);

   if (NUM_FLAGS < 2 || NUM_FLAGS != (1 << SEL_W)) begin : g_bad_flags
      initial $error("NUM_FLAGS must be a power of two, at least 2");
   end
   if (ADDR_W < SEL_W) begin : g_bad_addr
      initial $error("ADDR_W too narrow for NUM_FLAGS");
   end
   if (DATA_W < 1) begin : g_bad_data
      initial $error("DATA_W must be at least 1");
   end

   logic                 l_acc_rd, r_acc_rd;
   logic [SEL_W-1:0]     l_idx, r_idx;
   logic [NUM_FLAGS-1:0] l_req, l_rel, r_req, r_rel;
   logic [NUM_FLAGS-1:0] view_l, view_r;

   sem_port_decode #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dec_l (
      .sem_n(l_sem_n), .ce_n(l_ce_n), .we_n(l_we_n), .be0_n(l_be0_n),
      .addr(l_addr), .wdata(l_wdata),
      .acc_rd(l_acc_rd), .idx(l_idx), .req(l_req), .rel(l_rel));

   sem_port_decode #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dec_r (
      .sem_n(r_sem_n), .ce_n(r_ce_n), .we_n(r_we_n), .be0_n(r_be0_n),
      .addr(r_addr), .wdata(r_wdata),
      .acc_rd(r_acc_rd), .idx(r_idx), .req(r_req), .rel(r_rel));

   for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
      sem_flag_cell i_cell (
         .clk(clk), .rst_n(rst_n),
         .req_l(l_req[f]), .rel_l(l_rel[f]),
         .req_r(r_req[f]), .rel_r(r_rel[f]),
         .view_l(view_l[f]), .view_r(view_r[f]));
   end

   sem_read_port #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) i_rd_l (
      .clk(clk), .rst_n(rst_n), .acc_rd(l_acc_rd), .idx(l_idx),
      .view(view_l), .rdata(l_rdata));

   sem_read_port #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) i_rd_r (
      .clk(clk), .rst_n(rst_n), .acc_rd(r_acc_rd), .idx(r_idx),
      .view(view_r), .rdata(r_rdata));

   assert_one_flag_l_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(l_req | l_rel));

   assert_one_flag_r_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(r_req | r_rel));

   assert_never_shared_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (view_l | view_r) == '1);
endmodule

// File: tb/test_sem_flag_bank.sv
module test_sem_flag_bank;
   localparam int NF = 8;
   localparam int AW = 6;
   localparam int DW = 8;

   // operation codes used by the bench
   localparam int OP_IDLE = 0, OP_RD = 1, OP_REQ = 2, OP_REL = 3,
                  OP_NOSEM = 4, OP_NOCE = 5, OP_NOBE = 6, OP_RDNOCE = 7;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic l_sem_n, l_ce_n, l_we_n, l_be0_n, r_sem_n, r_ce_n, r_we_n, r_be0_n;
   logic [AW-1:0] l_addr, r_addr;
   logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;

   int total = 0;
   int bad = 0;
   int salt = 0;
   bit done = 1'b0;
   int own [NF];   // 0 free, 1 left, 2 right
   bit pnd [NF];

   always #2 clk = ~clk;

   sem_flag_bank #(.NUM_FLAGS(NF), .ADDR_W(AW), .DATA_W(DW)) i_sem_flag_bank (
      .clk(clk), .rst_n(rst_n),
      .l_sem_n(l_sem_n), .l_ce_n(l_ce_n), .l_we_n(l_we_n), .l_be0_n(l_be0_n),
      .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
      .r_sem_n(r_sem_n), .r_ce_n(r_ce_n), .r_we_n(r_we_n), .r_be0_n(r_be0_n),
      .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata));

   task automatic drive(input int op, input int idx, input int s,
                        output logic sem_n, output logic ce_n, output logic we_n,
                        output logic be_n, output logic [AW-1:0] addr,
                        output logic [DW-1:0] wd);
      logic [6:0] hi;
      hi = 7'(s * 37 + 5);
      sem_n = 1'b0; ce_n = 1'b0; be_n = 1'b0; we_n = 1'b1;
      addr = {hi[2:0], idx[2:0]};
      wd = {hi, 1'b0};
      case (op)
         OP_IDLE:   begin sem_n = 1'b1; ce_n = 1'b1; be_n = 1'b1; end
         OP_RD:     ;
         OP_REQ:    we_n = 1'b0;
         OP_REL:    begin we_n = 1'b0; wd = {hi, 1'b1}; end
         OP_NOSEM:  begin we_n = 1'b0; sem_n = 1'b1; end
         OP_NOCE:   begin we_n = 1'b0; ce_n = 1'b1; end
         OP_NOBE:   begin we_n = 1'b0; be_n = 1'b1; end
         default:   ce_n = 1'b1;   // read with chip disabled
      endcase
   endtask

   function automatic logic [DW-1:0] seen(int o, int side);
      return (o == side) ? '0 : '1;
   endfunction

   task automatic check(input string tag, input string who,
                        input logic [DW-1:0] act, input logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s rdata: actual=%h expected=%h", tag, who, act, exp);
      end
   endtask

   // one clock: both ports act, model updates, reads checked next cycle
   task automatic step(input int lop, input int li, input int rop, input int ri,
                       input string tag);
      logic [DW-1:0] el, er;
      salt++;
      drive(lop, li, salt, l_sem_n, l_ce_n, l_we_n, l_be0_n, l_addr, l_wdata);
      drive(rop, ri, salt + 3, r_sem_n, r_ce_n, r_we_n, r_be0_n, r_addr, r_wdata);
      el = (lop == OP_RD) ? seen(own[li], 1) : '1;
      er = (rop == OP_RD) ? seen(own[ri], 2) : '1;
      for (int f = 0; f < NF; f++) begin
         bit lq, ll, rq, rl;
         lq = (f == li) && (lop == OP_REQ);
         ll = (f == li) && (lop == OP_REL);
         rq = (f == ri) && (rop == OP_REQ);
         rl = (f == ri) && (rop == OP_REL);
         if (own[f] == 0) begin
            if (lq) begin own[f] = 1; pnd[f] = rq; end
            else if (rq) begin own[f] = 2; pnd[f] = 1'b0; end
         end else if (own[f] == 1) begin
            if (ll) begin own[f] = (pnd[f] || rq) ? 2 : 0; pnd[f] = 1'b0; end
            else if (rq) pnd[f] = 1'b1;
            else if (rl) pnd[f] = 1'b0;
         end else begin
            if (rl) begin own[f] = (pnd[f] || lq) ? 1 : 0; pnd[f] = 1'b0; end
            else if (lq) pnd[f] = 1'b1;
            else if (ll) pnd[f] = 1'b0;
         end
      end
      @(posedge clk);
      @(negedge clk);
      check(tag, "left", l_rdata, el);
      check(tag, "right", r_rdata, er);
   endtask

   initial begin
      for (int f = 0; f < NF; f++) begin own[f] = 0; pnd[f] = 1'b0; end
      drive(OP_IDLE, 0, 0, l_sem_n, l_ce_n, l_we_n, l_be0_n, l_addr, l_wdata);
      drive(OP_IDLE, 0, 0, r_sem_n, r_ce_n, r_we_n, r_be0_n, r_addr, r_wdata);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      check("R1", "left", l_rdata, '1);
      check("R1", "right", r_rdata, '1);
      for (int f = 0; f < NF; f++) step(OP_RD, f, OP_RD, f, "R1");

      // R4: claim with upper data bits set, then readback
      step(OP_REQ, 5, OP_IDLE, 0, "R4");
      step(OP_RD, 5, OP_RD, 5, "R4");
      // R9: owner re-claims, other port frees a flag it does not own
      step(OP_REQ, 5, OP_REL, 5, "R9");
      step(OP_RD, 5, OP_RD, 5, "R9");
      // R6: owner frees
      step(OP_REL, 5, OP_IDLE, 0, "R6");
      step(OP_RD, 5, OP_RD, 5, "R6");
      // R2: disqualified writes leave the flag free
      step(OP_NOSEM, 1, OP_NOCE, 1, "R2");
      step(OP_NOBE, 1, OP_RDNOCE, 1, "R2");
      step(OP_RD, 1, OP_RD, 1, "R2");
      // R3: claim flag 3, neighbours unaffected, upper addr ignored
      step(OP_REQ, 3, OP_IDLE, 0, "R3");
      step(OP_RD, 2, OP_RD, 3, "R3");
      step(OP_RD, 4, OP_RD, 3, "R3");
      // R7: right waits on flag 3, gets it when left frees
      step(OP_RD, 3, OP_REQ, 3, "R7");
      step(OP_REL, 3, OP_RD, 3, "R7");
      step(OP_RD, 3, OP_RD, 3, "R7");
      // R9: left pends on flag 3 then cancels; right frees -> free
      step(OP_REQ, 3, OP_IDLE, 0, "R9");
      step(OP_REL, 3, OP_IDLE, 0, "R9");
      step(OP_IDLE, 0, OP_REL, 3, "R9");
      step(OP_RD, 3, OP_RD, 3, "R9");
      // R8: same-cycle tie on free flag 6, then handoff
      step(OP_REQ, 6, OP_REQ, 6, "R8");
      step(OP_RD, 6, OP_RD, 6, "R8");
      step(OP_REL, 6, OP_IDLE, 0, "R8");
      step(OP_RD, 6, OP_RD, 6, "R8");
      step(OP_IDLE, 0, OP_REL, 6, "R6");
      step(OP_RD, 6, OP_RD, 6, "R6");

      // R5: sweep of every op pair, same flag and neighbouring flag
      for (int f = 0; f < NF; f++)
         for (int lo = 0; lo < 8; lo++)
            for (int ro = 0; ro < 8; ro++) begin
               step(lo, f, ro, f, "R5");
               step(OP_RD, f, OP_RD, f, "R5");
               step(ro, f, lo, (f + 1) % NF, "R5");
               step(OP_RD, (f + 1) % NF, OP_RD, f, "R5");
            end
      for (int f = 0; f < NF; f++) step(OP_RD, f, OP_RD, f, "R5");

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule